// File: doc/BRIEF.md
# Segment ID Multiplicative Scrambler

This block turns an effective address into a scattered 36-bit virtual segment identifier. A request carries a 64-bit effective address, a privilege select and a 20-bit address-space context number. The effective segment number is the address shifted right by 28.

The block first builds a 36-bit intermediate identifier. For a privileged request this identifier is the full segment number. For an unprivileged request it is the context number above the low 15 segment-number bits, so its top bit is always clear. The intermediate identifier is then multiplied by the prime 200730139 and reduced modulo 2^36-1. The reduction has no divider: the upper and lower parts of the product are added with an end-around fold, and one conditional increment follows. The result is a one-to-one mapping that spreads neighbouring segments across a hash table.

Requests flow through a three-stage pipeline with valid/ready handshakes on both sides. A beat is accepted when `in_valid` and `in_ready` are both high on a rising edge. A result leaves when `out_valid` and `out_ready` are both high. While the output holds a result that has not been taken, the whole pipeline freezes and `in_ready` stays low. When the consumer keeps `out_ready` high, one request is accepted every cycle. An error flag travels with each result. It marks a privileged intermediate identifier that falls in a reserved range.

Top module: `vsid_scrambler`

## Requirements
- R1: For an unprivileged request (`in_kernel`=0) the intermediate identifier is {0, `in_ctx`[19:0], `in_ea`[42:28]}. Address bits 63:43 and 27:0 have no effect on the result.
- R2: For a privileged request (`in_kernel`=1) the intermediate identifier is `in_ea`[63:28].
- R3: `out_vsid` equals (intermediate identifier × 200730139) mod (2^36−1).
- R4: `out_vsid` is never the all-ones 36-bit value whenever `out_valid` is high.
- R5: `out_err` is 1 exactly when the request was privileged and its intermediate identifier is all ones, or has bits 35:34 equal to 2'b10. Unprivileged requests never set it.
- R6: With `out_ready` held high, a request accepted on edge k appears with `out_valid`=1 after edge k+2, and `in_ready` stays high so that one request is taken every cycle.
- R7: While `out_valid`=1 and `out_ready`=0, `out_vsid` and `out_err` hold steady and `in_ready` is low. Results leave in acceptance order, with none lost or duplicated. With `out_valid`=0, `in_ready` is high.
- R8: During and right after reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this edge if valid |
| in_ea | input | 64 | Effective address |
| in_kernel | input | 1 | 1 = privileged request, 0 = unprivileged |
| in_ctx | input | 20 | Address-space context number |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_vsid | output | 36 | Scrambled segment identifier |
| out_err | output | 1 | Request used a reserved identifier |

## Verification
A wrong product or a bad fold shows up directly as a wrong `out_vsid` on the beat that leaves the pipeline three edges after it was accepted. Because the mapping is one-to-one, a single flipped internal bit cannot be hidden by later inputs. A missing or stuck correction shows up at once for identifiers whose folded sum lands on 2^36−1, such as the all-ones input, which must map to zero. A stall-control fault shows up within one cycle of a back-pressure change, as a changed held output, a lost beat, a duplicated beat or an out-of-order beat. The bench checks results against a modulo computed in the bench, across a sweep of contexts, segment numbers and edge values, under a mixed ready pattern.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  localparam int unsigned EA_W_D      = 64;
  localparam int unsigned SEG_SHIFT_D = 28;
  localparam int unsigned ID_W_D      = 36;
  localparam int unsigned CTX_W_D     = 20;
  localparam int unsigned UESID_W_D   = 15;
  localparam int unsigned MULT_W_D    = 28;
  localparam longint unsigned MULT_D  = 64'd200730139;
endpackage

// File: rtl/vsid_proto_form.sv
module vsid_proto_form #(
  parameter int unsigned EA_W      = vsid_pkg::EA_W_D,
  parameter int unsigned SEG_SHIFT = vsid_pkg::SEG_SHIFT_D,
  parameter int unsigned ID_W      = vsid_pkg::ID_W_D,
  parameter int unsigned CTX_W     = vsid_pkg::CTX_W_D,
  parameter int unsigned UESID_W   = vsid_pkg::UESID_W_D
) (
  input  logic [EA_W-1:0]  ea,
  input  logic             kernel,
  input  logic [CTX_W-1:0] ctx,
  output logic [ID_W-1:0]  proto,
  output logic             err
);
  localparam int unsigned USER_W = CTX_W + UESID_W;

  logic [ID_W-1:0] seg;
  logic [ID_W-1:0] user_id;

  always_comb begin
    seg     = ea[SEG_SHIFT +: ID_W];
    user_id = ID_W'({ctx, seg[UESID_W-1:0]});
    proto   = kernel ? seg : user_id;
    // reserved: all ones, or privileged prefix 2'b10
    err     = kernel && ((&seg) || (seg[ID_W-1 -: 2] == 2'b10));
  end
endmodule

// File: rtl/vsid_mul_stage.sv
module vsid_mul_stage #(
  parameter int unsigned ID_W   = vsid_pkg::ID_W_D,
  parameter int unsigned MULT_W = vsid_pkg::MULT_W_D,
  parameter longint unsigned MULT = vsid_pkg::MULT_D,
  localparam int unsigned PROD_W = ID_W + MULT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              v_in,
  input  logic [ID_W-1:0]   proto,
  input  logic              err_in,
  output logic              v_out,
  output logic [PROD_W-1:0] prod,
  output logic              err_out
);
  localparam logic [PROD_W-1:0] K = PROD_W'(MULT);

  logic [PROD_W-1:0] prod_d;
  assign prod_d = PROD_W'(proto) * K;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= 1'b0;
    else if (en) v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      prod    <= prod_d;
      err_out <= err_in;
    end
  end
endmodule

// File: rtl/vsid_fold_stage.sv
module vsid_fold_stage #(
  parameter int unsigned ID_W   = vsid_pkg::ID_W_D,
  parameter int unsigned MULT_W = vsid_pkg::MULT_W_D,
  localparam int unsigned PROD_W = ID_W + MULT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              v_in,
  input  logic [PROD_W-1:0] prod,
  input  logic              err_in,
  output logic              v_out,
  output logic [ID_W:0]     sum,
  output logic              err_out
);
  logic [ID_W:0] sum_d;
  // end-around fold: 2^ID_W == 1 modulo 2^ID_W-1
  assign sum_d = (ID_W+1)'(prod[PROD_W-1:ID_W]) + (ID_W+1)'(prod[ID_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= 1'b0;
    else if (en) v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum     <= sum_d;
      err_out <= err_in;
    end
  end
endmodule

// File: rtl/vsid_correct_stage.sv
module vsid_correct_stage #(
  parameter int unsigned ID_W = vsid_pkg::ID_W_D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            v_in,
  input  logic [ID_W:0]   sum,
  input  logic            err_in,
  output logic            v_out,
  output logic [ID_W-1:0] vsid,
  output logic            err_out
);
  logic [ID_W:0]   bumped;
  logic [ID_W:0]   fixed;
  logic [ID_W-1:0] vsid_d;

  always_comb begin
    bumped = sum + 1'b1;
    fixed  = sum + (ID_W+1)'(bumped[ID_W]);
    vsid_d = fixed[ID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= 1'b0;
    else if (en) v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      vsid    <= vsid_d;
      err_out <= err_in;
    end
  end
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler #(
  parameter int unsigned EA_W      = vsid_pkg::EA_W_D,
  parameter int unsigned SEG_SHIFT = vsid_pkg::SEG_SHIFT_D,
  parameter int unsigned ID_W      = vsid_pkg::ID_W_D,
  parameter int unsigned CTX_W     = vsid_pkg::CTX_W_D,
  parameter int unsigned UESID_W   = vsid_pkg::UESID_W_D,
  parameter int unsigned MULT_W    = vsid_pkg::MULT_W_D,
  parameter longint unsigned MULT  = vsid_pkg::MULT_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [EA_W-1:0]  in_ea,
  input  logic             in_kernel,
  input  logic [CTX_W-1:0] in_ctx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_vsid,
  output logic             out_err
);
  localparam int unsigned PROD_W = ID_W + MULT_W;

  logic              adv;
  logic [ID_W-1:0]   proto;
  logic              err0;
  logic              v1, e1, v2, e2;
  logic [PROD_W-1:0] prod1;
  logic [ID_W:0]     sum2;

  // single stall domain: everything advances when the output slot frees
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  vsid_proto_form #(
    .EA_W(EA_W), .SEG_SHIFT(SEG_SHIFT), .ID_W(ID_W),
    .CTX_W(CTX_W), .UESID_W(UESID_W)
  ) u_form (
    .ea(in_ea), .kernel(in_kernel), .ctx(in_ctx), .proto(proto), .err(err0)
  );

  vsid_mul_stage #(.ID_W(ID_W), .MULT_W(MULT_W), .MULT(MULT)) u_mul (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(in_valid), .proto(proto),
    .err_in(err0), .v_out(v1), .prod(prod1), .err_out(e1)
  );

  vsid_fold_stage #(.ID_W(ID_W), .MULT_W(MULT_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(v1), .prod(prod1),
    .err_in(e1), .v_out(v2), .sum(sum2), .err_out(e2)
  );

  vsid_correct_stage #(.ID_W(ID_W)) u_fix (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(v2), .sum(sum2),
    .err_in(e2), .v_out(out_valid), .vsid(out_vsid), .err_out(out_err)
  );
endmodule

// File: rtl/vsid_scrambler_checker.sv
module vsid_scrambler_checker #(
  parameter int unsigned ID_W = vsid_pkg::ID_W_D
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [ID_W-1:0] out_vsid,
  input logic            out_err
);
  // R7: held result stays put under back-pressure
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vsid) && $stable(out_err)));

  // R7: empty output slot never blocks input
  p_idle_accepts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R4: reserved all-ones code never produced
  p_no_reserved_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vsid != {ID_W{1'b1}}));

  // R3: a presented result is fully defined
  p_known_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown({out_vsid, out_err}));

  // R7: stalled output blocks intake
  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind vsid_scrambler vsid_scrambler_checker #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_vsid(out_vsid), .out_err(out_err)
);

// File: tb/vsid_scrambler_test.sv
`timescale 1ns/1ps
module vsid_scrambler_test;
  localparam int N = 200;
  localparam longint unsigned M   = 64'd200730139;
  localparam longint unsigned MOD = 64'h0000_000F_FFFF_FFFF;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_ea = '0;
  logic        in_kernel = 1'b0;
  logic [19:0] in_ctx = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [35:0] out_vsid;
  logic        out_err;

  int checks = 0;
  int errors = 0;

  logic [63:0] it_ea [N];
  logic        it_k  [N];
  logic [19:0] it_c  [N];
  logic [35:0] it_v  [N];
  logic        it_e  [N];

  always #2.5 clk = ~clk;

  vsid_scrambler uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ea(in_ea), .in_kernel(in_kernel), .in_ctx(in_ctx),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_vsid(out_vsid), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] scramble(input logic [35:0] p);
    longint unsigned prod;
    prod = longint'(p) * M;
    return 36'(prod % MOD);
  endfunction

  task automatic set_item(input int i, input logic [35:0] proto,
                          input logic k, input logic [19:0] c, input logic [63:0] ea);
    it_ea[i] = ea;
    it_k[i]  = k;
    it_c[i]  = c;
    it_v[i]  = scramble(proto);
    it_e[i]  = k && ((proto == 36'hF_FFFF_FFFF) || (proto[35:34] == 2'b10));
  endtask

  task automatic build();
    logic [35:0] edges [8];
    edges = '{36'hF_FFFF_FFFF, 36'hF_FFFF_FFFE, 36'h8_0000_0000, 36'hB_FFFF_FFFF,
              36'h0_0000_0000, 36'h7_FFFF_FFFF, 36'hC_0000_0000, 36'h0_0000_0001};
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 16; k++) begin
        logic [19:0] ctx;
        logic [14:0] lo;
        logic [20:0] junk_hi;
        logic [27:0] junk_lo;
        ctx = (c == 0) ? 20'h0 : (c == 7) ? 20'hFFFFF : 20'(c * 32'h2F35B);
        lo  = (k == 0) ? 15'h0 : (k == 15) ? 15'h7FFF : 15'(k * 32'h1357 + c * 7);
        junk_hi = 21'(k * c * 32'h1ABCD);
        junk_lo = 28'(k * 32'h0123457);
        // R1: upper segment bits and page offset are junk for user requests
        set_item(c * 16 + k, {1'b0, ctx, lo}, 1'b0, ctx, {junk_hi, lo, junk_lo});
      end
    end
    for (int j = 0; j < 64; j++) begin
      logic [35:0] p;
      p = {2'b11, 34'(j * 64'h0F0F0F0F1)};
      set_item(128 + j, p, 1'b1, 20'(j * 977), {p, 28'(j * 32'h0777777)});
    end
    for (int e = 0; e < 8; e++)
      set_item(192 + e, edges[e], 1'b1, 20'hABCDE, {edges[e], 28'hFFFFFFF});
  endtask

  task automatic present(input int i);
    if (i < N) begin
      in_valid  = 1'b1;
      in_ea     = it_ea[i];
      in_kernel = it_k[i];
      in_ctx    = it_c[i];
    end else begin
      in_valid = 1'b0;
    end
  endtask

  initial begin
    int idx, head, cyc;
    bit took;
    build();

    // R8: reset state
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid in reset", 64'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", 64'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid after reset", 64'(out_valid), 0);

    // R6: latency of a single request (user ctx 0, segment 1 -> multiplier)
    in_valid = 1'b1; in_kernel = 1'b0; in_ctx = '0; in_ea = 64'h1000_0000;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6", "valid after 1 edge", 64'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "valid after 2 edges", 64'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6", "valid after 3 edges", 64'(out_valid), 1);
    chk(out_vsid == 36'(M), "R3", "proto 1 result", 64'(out_vsid), M);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "single beat only", 64'(out_valid), 0);

    // stream: first half ready always high, then mixed back-pressure
    idx = 0; head = 0; cyc = 0; took = 1'b0;
    present(0);
    while (head < N && cyc < LIMIT) begin
      if (took) begin
        idx++;
        present(idx);
      end
      if (head < N / 2) out_ready = 1'b1;
      else out_ready = ((cyc % 7) != 3) && ((cyc % 11) < 7);
      #1;
      if (head < N / 2)
        chk(in_ready == 1'b1, "R6", "in_ready with ready high", 64'(in_ready), 1);
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R7", "in_ready under stall", 64'(in_ready), 0);
      if (out_valid && out_ready) begin
        chk(out_vsid == it_v[head], it_k[head] ? "R2/R3" : "R1/R3",
            $sformatf("vsid of item %0d", head), 64'(out_vsid), 64'(it_v[head]));
        chk(out_err == it_e[head], "R5", $sformatf("err of item %0d", head),
            64'(out_err), 64'(it_e[head]));
        chk(out_vsid != 36'hF_FFFF_FFFF, "R4", "reserved output", 64'(out_vsid), 0);
        head++;
      end
      took = in_valid && in_ready;
      @(negedge clk);
      cyc++;
    end
    if (cyc >= LIMIT)
      chk(1'b0, "R7", "watchdog: results missing", 64'(head), 64'(N));

    // R7: nothing extra comes out afterwards
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7", "no duplicate beat", 64'(out_valid), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule